// File: doc/BRIEF.md
# Serialized Interrupt Slot Agent

This block is the peripheral side of a serialized interrupt line. The line is shared, pulled high, and clocked by the bus clock. The block watches the line for a start frame, whether the host drove it or the block kicked it off itself. It then counts three-clock slots: sample, recovery and turnaround. For each slot it owns that has an active request, it pulls the line low in the sample phase and drives it high in the recovery phase.

At the end of a cycle the block measures how long the closing low pulse lasts. A short pulse selects quiet operation for the next cycle. In quiet operation the block may open a cycle itself with a one-clock low pulse, which the host then extends. A longer pulse selects continuous operation, in which only the host opens cycles.

The line is modelled as three signals: a sampled input, a driven value and an output enable. An external model resolves these into the wired line. Requests and slot ownership arrive as vectors with one bit per slot. Only slots 3, 4, 5, 7, 9, 10 and 11 can ever be driven.

Top module: `serirq_agent`

## Requirements
- R1: After reset the block is in continuous operation: it leaves `sirq_oe` low and never opens a cycle itself, even with owned requests active.
- R2: While no cycle is in progress (after a stop frame and before the next start frame) `sirq_oe` stays low, except for a self-start pulse under R7.
- R3: Let edge 1 be the first rising edge at which the line is sampled high after a start-frame low. Slot k (numbered from 0) has its sample phase in the clock period after edge 3k+2. In that period the block drives low (`sirq_oe`=1, `sirq_out`=0) when slot k is eligible.
- R4: A slot is eligible only when its `irq_req` bit and its `slot_own` bit are both 1. In every other period of a cycle, and in the sample phase of a slot that is not eligible, `sirq_oe` is 0.
- R5: The period after a sample phase the block drove low is a recovery phase, in which it drives high (`sirq_oe`=1, `sirq_out`=1). In the turnaround period that follows it releases the line (`sirq_oe`=0).
- R6: Only slots 3, 4, 5, 7, 9, 10 and 11 are supported. A request on any other slot is never driven, even when that slot is owned.
- R7: In quiet operation, once idle, the block opens a cycle whenever some slot is eligible. It drives low for exactly one clock period and releases in the next. It does not self-start when no slot is eligible.
- R8: A stop frame held low for 3 or more clocks selects continuous operation, in which the block does not self-start.
- R9: The block never self-starts between a start frame and the stop frame that ends that cycle, even if a request appears mid-cycle. It self-starts only after the stop frame, when quiet operation applies.
- R10: Single-clock lows from other agents during a cycle do not end the cycle. Slot counting and driving continue unchanged.
- R11: A cycle opened by the block's own one-clock pulse and extended low by the host is counted exactly as in R3, from the first sampled-high edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SLOTS | Interrupt request, one bit per slot |
| slot_own | input | NUM_SLOTS | Ownership enable, one bit per slot |
| sirq_in | input | 1 | Resolved level of the shared line |
| sirq_out | output | 1 | Value driven onto the line while enabled |
| sirq_oe | output | 1 | Output enable for the line driver |

## Verification
The bench builds the block with the default of 16 slots. Sample points therefore reach clock 47, which places both the unsupported slots below 3 and the one at 15 inside the counted window alongside every supported slot. Short (2-clock) and long (3-clock) stop pulses are both used, as are start lows of 4 to 8 clocks. Foreign single-clock lows are injected into unowned slots. A request is raised mid-cycle in quiet operation, so the bench can see when a self-start may and may not happen.

// File: rtl/serirq_pkg.sv
// Package: shared state encoding and slot support table for the serialized
// interrupt agent. Assumes slots are numbered from 0 in cycle order.
package serirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_KICK   = 2'd1,
        ST_START  = 2'd2,
        ST_ACTIVE = 2'd3
    } frame_st_e;

    // Slots this agent is permitted to drive.
    function automatic logic slot_supported(input int k);
        return (k == 3) || (k == 4) || (k == 5) || (k == 7) ||
               (k == 9) || (k == 10) || (k == 11);
    endfunction

endpackage

// File: rtl/serirq_frame_tracker.sv
// Frame tracker: follows the shared line through idle, self-start, start
// frame and active cycle. Counts clocks from the first high sample after the
// start low. Measures the stop-pulse width to pick quiet or continuous mode.
// Assumes sirq_in is already synchronous to clk.
module serirq_frame_tracker
    import serirq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             kick_req,
    output frame_st_e        st,
    output logic [CNT_W-1:0] pcnt,
    output logic             quiet
);

    localparam logic [CNT_W-1:0] PCNT_MAX = '1;

    logic [1:0] lowrun;

    // Purpose: advance the frame state, phase count, low-run length and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pcnt   <= '0;
            lowrun <= '0;
            quiet  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (!line_in)
                        st <= ST_START;
                    else if (quiet && kick_req)
                        st <= ST_KICK;
                end
                ST_KICK: st <= ST_START;
                ST_START: begin
                    if (line_in) begin
                        st     <= ST_ACTIVE;
                        pcnt   <= CNT_W'(1);
                        lowrun <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (pcnt != PCNT_MAX)
                        pcnt <= pcnt + 1'b1;
                    if (!line_in) begin
                        if (lowrun != 2'd3)
                            lowrun <= lowrun + 1'b1;
                    end else begin
                        if (lowrun >= 2'd2) begin
                            st    <= ST_IDLE;
                            quiet <= (lowrun == 2'd2);
                        end
                        lowrun <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serirq_slot_driver.sv
// Slot driver: decides per clock whether the agent drives low (sample phase
// of an eligible slot) or high (recovery after its own low). Also flags
// any eligible request for self-start. Assumes pcnt counts from 1 on the
// first high sample after the start frame.
module serirq_slot_driver
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int CNT_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  frame_st_e            st,
    input  logic [CNT_W-1:0]     pcnt,
    input  logic [NUM_SLOTS-1:0] irq_req,
    input  logic [NUM_SLOTS-1:0] slot_own,
    output logic                 drv_low,
    output logic                 drv_high,
    output logic                 pending
);

    logic [NUM_SLOTS-1:0] eligible;
    logic [NUM_SLOTS-1:0] hit;
    logic                 drove_q;

    // Per-slot eligibility and sample-point match.
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam logic             SUP_BIT   = slot_supported(k);
        localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(3 * k + 2);
        assign eligible[k] = irq_req[k] & slot_own[k] & SUP_BIT;
        assign hit[k]      = (pcnt == SAMPLE_AT);
    end

    // Purpose: combine slot matches into the low drive and pending flag.
    always_comb begin
        drv_low  = (st == ST_ACTIVE) && |(eligible & hit);
        drv_high = drove_q && (st == ST_ACTIVE);
        pending  = |eligible;
    end

    // Purpose: remember a low drive so the next period becomes recovery.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drove_q <= 1'b0;
        else
            drove_q <= drv_low;
    end

endmodule

// File: rtl/serirq_agent.sv
// Top: serialized interrupt slot agent. Joins the frame tracker and the slot
// driver and resolves them into one enable/value pair for the shared line.
// Assumes an external pull-up and an open line model.
module serirq_agent
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] irq_req,
    input  logic [NUM_SLOTS-1:0] slot_own,
    input  logic                 sirq_in,
    output logic                 sirq_out,
    output logic                 sirq_oe
);

    localparam int CNT_W = $clog2(3 * NUM_SLOTS + 4);

    frame_st_e        st;
    logic [CNT_W-1:0] pcnt;
    logic             quiet;
    logic             drv_low;
    logic             drv_high;
    logic             pending;

    serirq_frame_tracker #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (sirq_in),
        .kick_req (pending),
        .st       (st),
        .pcnt     (pcnt),
        .quiet    (quiet)
    );

    serirq_slot_driver #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .pcnt     (pcnt),
        .irq_req  (irq_req),
        .slot_own (slot_own),
        .drv_low  (drv_low),
        .drv_high (drv_high),
        .pending  (pending)
    );

    // Purpose: merge self-start, sample and recovery drives onto the line.
    always_comb begin
        sirq_oe  = (st == ST_KICK) | drv_low | drv_high;
        sirq_out = drv_high;
    end

endmodule

// File: rtl/serirq_agent_chk.sv
// Checker: temporal properties of the agent's line drive, bound to the top.
module serirq_agent_chk
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input frame_st_e            st,
    input logic                 quiet,
    input logic [NUM_SLOTS-1:0] irq_req,
    input logic [NUM_SLOTS-1:0] slot_own,
    input logic                 sirq_out,
    input logic                 sirq_oe
);

    logic [NUM_SLOTS-1:0] sup_mask;
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_sup
        assign sup_mask[k] = slot_supported(k);
    end

    // R2: released while idle
    p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sirq_oe);

    // R8: drive outside a cycle only happens in quiet operation
    p_kick_quiet_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && st != ST_ACTIVE) |-> quiet);

    // R7: self-start lasts exactly one clock
    p_kick_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KICK) |=> !sirq_oe);

    // R5: low sample is followed by high recovery
    p_recovery_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && sirq_oe && !sirq_out) |=> (sirq_oe && sirq_out));

    // R5: recovery is followed by release
    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_out) |=> !sirq_oe);

    // R6: a low drive in a cycle needs an eligible supported slot
    p_supported_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && sirq_oe && !sirq_out) |->
            ($countones(irq_req & slot_own & sup_mask) != 0));

    // R9: no self-start straight out of an active cycle
    p_no_kick_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE) |=> (st != ST_KICK));

endmodule

bind serirq_agent serirq_agent_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .quiet    (quiet),
    .irq_req  (irq_req),
    .slot_own (slot_own),
    .sirq_out (sirq_out),
    .sirq_oe  (sirq_oe)
);

// File: tb/serirq_agent_tb.sv
module serirq_agent_tb;

    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [NS-1:0] slot_own = '0;
    logic          bus_oe = 1'b0;
    logic          bus_val = 1'b1;
    logic          sirq_out;
    logic          sirq_oe;
    logic          sirq_line;
    int            n_checks = 0;
    int            n_errors = 0;

    always #2 clk = ~clk;

    // Wired line with pull-up: agent, else host/other, else high.
    assign sirq_line = sirq_oe ? sirq_out : (bus_oe ? bus_val : 1'b1);

    serirq_agent #(.NUM_SLOTS(NS)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .slot_own (slot_own),
        .sirq_in  (sirq_line),
        .sirq_out (sirq_out),
        .sirq_oe  (sirq_oe)
    );

    task automatic chk(input string tag, input bit e_oe, input bit e_out);
        n_checks++;
        if (sirq_oe !== e_oe || (e_oe && sirq_out !== e_out)) begin
            n_errors++;
            $display("FAIL %s: actual oe=%b out=%b expected oe=%b out=%b at %0t",
                     tag, sirq_oe, sirq_out, e_oe, e_out, $time);
        end
    endtask

    // One cycle: start low (host, or host extending a self-start), then slots.
    task automatic run_cycle(input int low_len, input bit kicked,
                             input logic [NS-1:0] exp_mask,
                             input logic [NS-1:0] other_mask,
                             input bit late_en, input logic [NS-1:0] late_req,
                             input string tag);
        int nlow;
        nlow = kicked ? low_len - 1 : low_len;
        for (int i = 0; i < nlow; i++) begin
            @(posedge clk); #1 bus_oe = 1'b1; bus_val = 1'b0;
            #1 chk((kicked && i == 0) ? "R7" : tag, 1'b0, 1'b0);
        end
        @(posedge clk); #1 bus_val = 1'b1;
        #1 chk(tag, 1'b0, 1'b0);
        for (int p = 1; p <= 50; p++) begin
            bit    e_oe;
            bit    e_out;
            string t;
            @(posedge clk); #1 bus_oe = 1'b0;
            if (late_en && p == 30) irq_req = late_req;
            for (int k = 0; k < NS; k++)
                if (p == 3 * k + 2 && other_mask[k]) begin
                    bus_oe = 1'b1; bus_val = 1'b0;
                end
            e_oe = 1'b0; e_out = 1'b0; t = tag;
            for (int k = 0; k < NS; k++) begin
                if (p == 3 * k + 2 && exp_mask[k]) begin e_oe = 1'b1; e_out = 1'b0; t = "R3"; end
                if (p == 3 * k + 3 && exp_mask[k]) begin e_oe = 1'b1; e_out = 1'b1; t = "R5"; end
            end
            #1 chk(t, e_oe, e_out);
        end
    endtask

    // Stop frame of len low clocks, then idle or self-start checks.
    task automatic stop_frame(input int len, input bit exp_kick, input string tag);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1 bus_oe = 1'b1; bus_val = 1'b0;
            #1 chk(tag, 1'b0, 1'b0);
        end
        @(posedge clk); #1 bus_oe = 1'b0; bus_val = 1'b1;
        #1 chk(tag, 1'b0, 1'b0);
        @(posedge clk); #2 chk("R2", 1'b0, 1'b0);
        if (exp_kick) begin
            @(posedge clk); #2 chk("R7", 1'b1, 1'b0);
        end else begin
            for (int i = 0; i < 6; i++) begin
                @(posedge clk); #2 chk(tag, 1'b0, 1'b0);
            end
        end
    endtask

    // R1: continuous after reset, no self-start with an owned request.
    task automatic t_reset;
        irq_req = 16'h0010; slot_own = 16'hFFFF;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2 chk("R1", 1'b0, 1'b0);
        end
    endtask

    // R3/R4/R5 basic host cycle; long stop keeps continuous (R8).
    task automatic t_basic;
        irq_req = 16'h0018; slot_own = 16'hFFFF;
        run_cycle(4, 1'b0, 16'h0018, '0, 1'b0, '0, "R4");
        stop_frame(3, 1'b0, "R8");
    endtask

    // R6: unsupported slots 0, 6, 8, 15 ignored; slot 11 driven.
    task automatic t_unsupported;
        irq_req = 16'h8941; slot_own = 16'hFFFF;
        run_cycle(8, 1'b0, 16'h0800, '0, 1'b0, '0, "R6");
        stop_frame(3, 1'b0, "R8");
    endtask

    // R10 foreign lows; short stop, self-start (R7), counted cycle (R11).
    task automatic t_quiet;
        irq_req = 16'h06A0; slot_own = 16'h0420;
        run_cycle(5, 1'b0, 16'h0420, 16'h0046, 1'b0, '0, "R10");
        stop_frame(2, 1'b1, "R7");
        run_cycle(6, 1'b1, 16'h0420, '0, 1'b0, '0, "R11");
        irq_req = '0;
        stop_frame(2, 1'b0, "R7");
    endtask

    // R9: request appears mid-cycle in quiet mode; self-start waits for stop.
    task automatic t_no_kick_active;
        irq_req = '0; slot_own = 16'hFFFF;
        run_cycle(4, 1'b0, '0, '0, 1'b1, 16'h0010, "R9");
        stop_frame(2, 1'b1, "R9");
        run_cycle(4, 1'b1, 16'h0010, '0, 1'b0, '0, "R11");
        irq_req = '0;
        stop_frame(3, 1'b0, "R8");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_unsupported();
        t_quiet();
        t_no_kick_active();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R2: actual run still going expected finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule